// File: doc/BRIEF.md
# Watchdog Timer with Maskable Stall Inputs

This block watches over an embedded controller. Firmware programs an interval and turns the block on. From then on, firmware has to write the kick register again and again. Each kick reloads a down-counter. The counter steps down once per slow tick strobe, which is nominally 5 Hz and is supplied from outside. The tick arrives as a single-cycle pulse in the host clock domain.

If the counter runs out before the next kick, the block does three things:
- it emits a one-clock watchdog event pulse,
- it latches a sticky status flag,
- it restarts the countdown from the interval.

Three external stall lines can freeze the countdown, so that a known-busy condition does not cause a false event. Each stall line has its own mask bit in the control register. Stall line 2 is also forced active whenever the debug-enable input is low.

All register accesses take effect on the host clock, independent of the tick. Writes land on the next clock edge. Reads return the addressed register in the same cycle.

Top module: `stall_watchdog`

Register map:

| Address | Name | Access | Contents |
|---|---|---|---|
| 0 | CTRL | read/write | bit0 = enable; bits3:1 = stall mask, where bit 1+i enables stall line i |
| 1 | LOAD | read/write | 16-bit interval |
| 2 | KICK | write only | any write reloads the counter; reads return 0 |
| 3 | COUNT | read only | current counter value |
| 4 | STATUS | read / write-1-to-clear | bit0 = event flag |

## Requirements
- R1: After reset the block is in this state:
  - CTRL reads 0 and COUNT reads 0.
  - STATUS reads 0 and the event output is low.
  - LOAD reads the nonzero default of 10.
- R2: A CTRL write with bit0 = 1 while the block is disabled loads COUNT with the LOAD value on the next clock.
- R3: A tick while the block is enabled, unstalled and not being reloaded decreases COUNT by one, provided COUNT was above 1.
- R4: A tick that finds COUNT at 1 or 0 does two things on the same clock edge:
  - it raises the event output for exactly that one cycle;
  - it reloads COUNT from LOAD.

  A LOAD of 0 therefore fires on every tick.
- R5: STATUS bit0 sets together with each event. It is cleared only by writing 1 to STATUS bit0; writing 0 leaves it unchanged. If an event and a clear happen in the same cycle, the event wins.
- R6: A write to KICK reloads COUNT from LOAD. A kick takes priority over a tick in the same cycle, so that cycle produces no event.
- R7: While stall line i is high and CTRL bit 1+i is set, ticks are ignored and COUNT holds its value. A stall line whose mask bit is clear has no effect.
- R8: With CTRL bit3 set, debug-enable low stalls the counter even when stall line 2 is low.
- R9: With the block disabled, ticks change neither COUNT nor the event output.
- R10: Reads and writes behave as follows:
  - reads return the addressed register in the same cycle;
  - CTRL and LOAD read back what was written;
  - KICK and unmapped addresses (5 to 7) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Single-cycle slow tick strobe |
| stall_i | input | 3 | External stall lines |
| dbg_en_i | input | 1 | Debug enable; low forces stall line 2 active |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| wdt_event_o | output | 1 | One-cycle watchdog event pulse |

## Verification
The bench targets the following corner cases:
- **Kick and tick in the same cycle.** A design that lets the tick win would emit a spurious event.
- **Event and status clear in the same cycle.** A design that lets the clear win would lose an event.
- **Intervals of 0 and 1.** An off-by-one in the terminal compare would delay the event by a tick or wrap the counter to 0xFFFF.
- **Stall-line masking.** An unmasked line must not freeze counting, and debug-enable low must freeze it through mask bit 3. Swapping mask bits or dropping the debug term would show up as wrong COUNT readings.

Randomised traffic mixes all of these against a cycle model of the requirements.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int unsigned NUM_STALL = 3;
  localparam int unsigned ADDR_W    = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_LOAD   = 3'd1,
    A_KICK   = 3'd2,
    A_COUNT  = 3'd3,
    A_STATUS = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/swd_stall.sv
module swd_stall #(
  parameter int unsigned NSTALL  = 3,
  parameter int unsigned DBG_IDX = 2
) (
  input  logic [NSTALL-1:0] stall_i,
  input  logic [NSTALL-1:0] mask_i,
  input  logic              dbg_en_i,
  output logic              stall_o
);
  logic [NSTALL-1:0] line;

  // Line DBG_IDX also asserts whenever debug is disabled.
  for (genvar i = 0; i < NSTALL; i++) begin : g_line
    if (i == DBG_IDX) begin : g_dbg
      assign line[i] = stall_i[i] | ~dbg_en_i;
    end else begin : g_plain
      assign line[i] = stall_i[i];
    end
  end

  assign stall_o = |(line & mask_i);

  always_comb begin
    // R8
    if (mask_i[DBG_IDX] && !dbg_en_i) begin
      dbg_stall_chk: assert (stall_o);
    end
  end
endmodule

// File: rtl/swd_regs.sv
module swd_regs
  import swd_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned NSTALL   = 3,
  parameter logic [CNT_W-1:0] RST_LOAD = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              fire_i,
  output logic              en_o,
  output logic [NSTALL-1:0] mask_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              kick_o,
  output logic              arm_o
);
  localparam int unsigned CTRL_W = NSTALL + 1;

  logic              en_q, en_d;
  logic [NSTALL-1:0] mask_q, mask_d;
  logic [CNT_W-1:0]  load_q, load_d;
  logic              sts_q, sts_d;
  logic              wr_ctrl, wr_load, wr_kick, wr_sts;

  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_load = wr_en_i && (addr_i == A_LOAD);
  assign wr_kick = wr_en_i && (addr_i == A_KICK);
  assign wr_sts  = wr_en_i && (addr_i == A_STATUS);

  always_comb begin
    en_d   = en_q;
    mask_d = mask_q;
    load_d = load_q;
    sts_d  = sts_q;
    if (wr_ctrl) begin
      en_d   = wdata_i[0];
      mask_d = wdata_i[CTRL_W-1:1];
    end
    if (wr_load) load_d = wdata_i[CNT_W-1:0];
    if (fire_i) sts_d = 1'b1;
    else if (wr_sts && wdata_i[0]) sts_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '0;
      load_q <= RST_LOAD;
      sts_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      mask_q <= mask_d;
      load_q <= load_d;
      sts_q  <= sts_d;
    end
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign load_o = load_q;
  assign kick_o = wr_kick;
  assign arm_o  = wr_ctrl && wdata_i[0] && !en_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:   rdata_o[CTRL_W-1:0] = {mask_q, en_q};
      A_LOAD:   rdata_o[CNT_W-1:0]  = load_q;
      A_COUNT:  rdata_o[CNT_W-1:0]  = cnt_i;
      A_STATUS: rdata_o[0]          = sts_q;
      default:  rdata_o = '0;
    endcase
  end

  // R5
  sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> sts_q);
endmodule

// File: rtl/swd_counter.sv
module swd_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             stall_i,
  input  logic             arm_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o,
  output logic             evt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             evt_q, fire;
  logic             reload, step;

  assign reload = arm_i || kick_i;
  assign step   = en_i && tick_i && !stall_i;

  always_comb begin
    cnt_d = cnt_q;
    fire  = 1'b0;
    if (reload) begin
      cnt_d = load_i;
    end else if (step) begin
      if (cnt_q <= ONE) begin
        cnt_d = load_i;
        fire  = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      evt_q <= fire;
    end
  end

  assign cnt_o  = cnt_q;
  assign fire_o = fire;
  assign evt_o  = evt_q;

  // R3
  dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && !stall_i && !arm_i && !kick_i && cnt_q > ONE)
      |=> cnt_q == $past(cnt_q) - ONE);
  // R4
  evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> $past(tick_i && en_i));
  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i || kick_i) |=> (cnt_q == $past(load_i)) && !evt_q);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && stall_i && !arm_i && !kick_i) |=> $stable(cnt_q) && !evt_q);
  // R9
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !arm_i && !kick_i) |=> $stable(cnt_q) && !evt_q);
endmodule

// File: rtl/stall_watchdog.sv
module stall_watchdog
  import swd_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DBG_IDX  = 2,
  parameter logic [CNT_W-1:0] RST_LOAD = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic [NUM_STALL-1:0] stall_i,
  input  logic                 dbg_en_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 wdt_event_o
);
  logic [1:0]           rst_sync;
  logic                 rst_sn;
  logic                 en, kick, arm, stall, fire;
  logic [NUM_STALL-1:0] mask;
  logic [CNT_W-1:0]     load_val, cnt;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  swd_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .NSTALL(NUM_STALL), .RST_LOAD(RST_LOAD)
  ) u_regs (
    .clk(clk), .rst_n(rst_sn), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cnt_i(cnt), .fire_i(fire),
    .en_o(en), .mask_o(mask), .load_o(load_val), .kick_o(kick), .arm_o(arm)
  );

  swd_stall #(.NSTALL(NUM_STALL), .DBG_IDX(DBG_IDX)) u_stall (
    .stall_i(stall_i), .mask_i(mask), .dbg_en_i(dbg_en_i), .stall_o(stall)
  );

  swd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sn), .en_i(en), .tick_i(tick_i), .stall_i(stall),
    .arm_i(arm), .kick_i(kick), .load_i(load_val), .cnt_o(cnt),
    .fire_o(fire), .evt_o(wdt_event_o)
  );
endmodule

// File: tb/tb_stall_watchdog.sv
module tb_stall_watchdog;
  localparam logic [2:0] AC = 3'd0, AL = 3'd1, AK = 3'd2, AN = 3'd3, AS = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [2:0]  stall_i = '0;
  logic        dbg_en_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        wdt_event_o;

  int total = 0;
  int bad = 0;

  logic        m_en = 1'b0, m_sts = 1'b0, m_evt = 1'b0;
  logic [2:0]  m_mask = '0;
  logic [15:0] m_load = 16'd10, m_cnt = '0;

  stall_watchdog dut (.*);

  always #10 clk = ~clk;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_stall(logic [2:0] mk, logic [2:0] st, logic dbg);
    return |(mk & {st[2] | ~dbg, st[1:0]});
  endfunction

  task automatic model(logic tk, logic [2:0] st, logic dbg, logic wr,
                       logic [2:0] ad, logic [15:0] wd);
    logic stl = exp_stall(m_mask, st, dbg);
    logic fire = 1'b0;
    logic [15:0] n = m_cnt;
    if (wr && ad == AC && wd[0] && !m_en) n = m_load;
    else if (wr && ad == AK) n = m_load;
    else if (m_en && tk && !stl) begin
      if (m_cnt <= 16'd1) begin n = m_load; fire = 1'b1; end
      else n = m_cnt - 16'd1;
    end
    if (fire) m_sts = 1'b1;
    else if (wr && ad == AS && wd[0]) m_sts = 1'b0;
    if (wr && ad == AC) {m_mask, m_en} = wd[3:0];
    if (wr && ad == AL) m_load = wd;
    m_cnt = n;
    m_evt = fire;
  endtask

  task automatic peek(string tag, logic [2:0] ad, logic [15:0] exp);
    addr_i = ad;
    #1 check(tag, rdata_o, exp);
  endtask

  task automatic step(string tag, logic tk, logic [2:0] st, logic dbg,
                      logic wr, logic [2:0] ad, logic [15:0] wd);
    tick_i = tk; stall_i = st; dbg_en_i = dbg;
    wr_en_i = wr; addr_i = ad; wdata_i = wd;
    @(posedge clk);
    model(tk, st, dbg, wr, ad, wd);
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    check(tag, {15'd0, wdt_event_o}, {15'd0, m_evt});
    peek(tag, AN, m_cnt);
    peek(tag, AS, {15'd0, m_sts});
    peek(tag, AC, {12'd0, m_mask, m_en});
  endtask

  initial begin
    #4_000_000;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 event", {15'd0, wdt_event_o}, 16'd0);
    peek("R1 ctrl", AC, 16'd0);
    peek("R1 load", AL, 16'd10);
    peek("R1 count", AN, 16'd0);
    peek("R1 status", AS, 16'd0);
    // R10 readback and unmapped addresses
    step("R10", 0, 3'b000, 1, 1, AL, 16'd3);
    peek("R10 load", AL, 16'd3);
    peek("R10 kick reads 0", AK, 16'd0);
    peek("R10 unmapped", 3'd7, 16'd0);
    // R2 arm loads interval
    step("R2", 0, 3'b000, 1, 1, AC, 16'h0001);
    check("R2 count", m_cnt, 16'd3);
    // R3 decrement, R4 event at terminal count
    step("R3", 1, 3'b000, 1, 0, AN, 16'd0);
    step("R3", 1, 3'b000, 1, 0, AN, 16'd0);
    step("R4", 1, 3'b000, 1, 0, AN, 16'd0);
    check("R4 fired", {15'd0, m_evt}, 16'd1);
    step("R4 single pulse", 0, 3'b000, 1, 0, AN, 16'd0);
    // R5 write-0 keeps, write-1 clears
    step("R5 w0", 0, 3'b000, 1, 1, AS, 16'd0);
    step("R5 w1", 0, 3'b000, 1, 1, AS, 16'd1);
    // R5 event beats same-cycle clear (count 3 -> 1 first)
    step("R5", 1, 3'b000, 1, 0, AN, 16'd0);
    step("R5", 1, 3'b000, 1, 0, AN, 16'd0);
    step("R5 set wins", 1, 3'b000, 1, 1, AS, 16'd1);
    // R6 kick beats tick at terminal count
    step("R6", 1, 3'b000, 1, 0, AN, 16'd0);
    step("R6", 1, 3'b000, 1, 0, AN, 16'd0);
    step("R6 kick vs tick", 1, 3'b000, 1, 1, AK, 16'd0);
    // R7 mask line 0 only
    step("R7", 0, 3'b000, 1, 1, AC, 16'h0003);
    step("R7 unmasked", 1, 3'b010, 1, 0, AN, 16'd0);
    step("R7 masked", 1, 3'b001, 1, 0, AN, 16'd0);
    step("R7 masked", 1, 3'b001, 1, 0, AN, 16'd0);
    // R8 debug-enable low stalls via mask bit 3
    step("R8", 0, 3'b000, 1, 1, AC, 16'h0009);
    step("R8 dbg low", 1, 3'b000, 0, 0, AN, 16'd0);
    step("R8 dbg high", 1, 3'b000, 1, 0, AN, 16'd0);
    // R9 disabled ignores ticks
    step("R9", 0, 3'b000, 1, 1, AC, 16'h0000);
    for (int i = 0; i < 6; i++) step("R9", 1, 3'b000, 1, 0, AN, 16'd0);
    // R4 zero interval fires every tick
    step("R4", 0, 3'b000, 1, 1, AL, 16'd0);
    step("R4", 0, 3'b000, 1, 1, AC, 16'h0001);
    step("R4 zero", 1, 3'b000, 1, 0, AN, 16'd0);
    step("R4 zero", 1, 3'b000, 1, 0, AN, 16'd0);
    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic        tk  = ($urandom_range(2) == 0);
      logic [2:0]  st  = ($urandom_range(3) == 0) ? 3'($urandom) : 3'b000;
      logic        dbg = ($urandom_range(7) != 0);
      logic        wr  = ($urandom_range(5) == 0);
      logic [2:0]  ad  = 3'($urandom_range(5));
      logic [15:0] wd  = (ad == AL) ? 16'($urandom_range(6)) : 16'($urandom);
      step("R3/R4/R7 random", tk, st, dbg, wr, ad, wd);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule